// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single memory-to-peripheral DMA channel. It has two buffer descriptor slots. Software fills a slot with a byte count and a start address. The channel reads that buffer word by word through a memory request port and hands each word to a peripheral through a valid/ready handshake. While one slot is being drained, software can load the other one, so the stream continues without a gap. The channel tells software when it has run dry and when a slot has become free again. Both events come out through a masked interrupt line. A register window gives access to control, interrupt flags, channel state, the bytes still to go and the two descriptors.

Both data interfaces are valid/ready:

- **Memory request.** Once `mem_req_valid` rises, the request (valid and address) is held unchanged until `mem_req_ready` is seen high at a clock edge. Only one read is outstanding at a time. The read response is accepted without back-pressure, because a response is only legal while that single read is outstanding.
- **Peripheral output.** Once `per_valid` rises, `per_valid` and `per_data` are held until `per_ready` is high at a clock edge. A slow peripheral therefore stalls the channel without losing data.

Top module: `pdma_chan`

## Requirements
- R1: After reset, the status state field reads 0 (idle). The interrupt register reads 0, `irq` is low, the remaining count reads 0, and neither `mem_req_valid` nor `per_valid` is asserted.
- R2: The register offsets are:
  - 0x00: control
  - 0x04: interrupt flags
  - 0x08: port select
  - 0x0C: status
  - 0x14: remaining bytes
  - 0x20 / 0x24: slot 0 count / address
  - 0x30 / 0x34: slot 1 count / address

  A write to the port select register reads back unchanged and drives `per_port`.
- R3: Control bit 4 is the channel enable. A control write reaches the state machine only when control is next read. Status bits [5:4] encode the state: 0 idle, 1 stall, 2 on, 3 next. An enabled idle channel moves to stall.
- R4: Writing a slot's address register after its count register commits that slot, provided the channel is active, enabled and the slot is free. A commit moves the state stall→on or on→next. Writes to a loaded slot's registers are ignored and leave them unchanged. A commit while idle is ignored.
- R5: A buffer of N bytes is fetched from its start address upward in steps of the word size. It yields ceil(N/word bytes) peripheral words, in address order, each carrying the memory data for its address. N = 0 yields no words.
- R6: The remaining count starts at the buffer's byte count and drops by the word size on each peripheral handshake, saturating at 0.
- R7: When the active buffer ends while the other slot is loaded, the state goes next→on. The channel continues with the other slot and sets interrupt bit 1 (next free buffer).
- R8: When the active buffer ends with no other slot loaded, the state goes on→stall and interrupt bit 0 (stall) is set.
- R9: Interrupt bits 0 and 1 stay set until the next accepted commit clears them. Writing the interrupt register has no effect on them.
- R10: A memory response flagged as an error sets interrupt bit 3, drops the rest of the active buffer and advances as if that buffer had ended. Writing 1 to interrupt bit 3 clears it.
- R11: `irq` is the OR of each interrupt bit ANDed with its enable in control: bit 0 for stall, bit 1 for next free buffer, bit 3 for error. Enable changes act without a control read.
- R12: After the enable is cleared, buffers already loaded still finish. The channel then spends at least one cycle in stall before it goes idle, and it never goes straight from on to idle.
- R13: `mem_req_valid`/`mem_req_addr` and `per_valid`/`per_data` are held stable while their ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (also latches the enable) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |
| mem_rsp_err | input | 1 | Read failed |
| per_valid | output | 1 | Word for the peripheral valid |
| per_ready | input | 1 | Peripheral accepts word |
| per_data | output | DATA_W | Word for the peripheral |
| per_port | output | PORT_W | Peripheral port selection |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the channel with a 16-bit data path (2-byte words), 24-bit addresses and 12-bit counts. With 2-byte words, an odd byte count leaves a partial last word, which exercises the saturating remaining count. Short buffers of 0 to 14 bytes keep every buffer-end event, slot switch and stall within a few dozen cycles. The memory model drops its ready line on a fixed rhythm, and the peripheral model grants words from a budget. Together they exercise back-pressure on both interfaces and hold the channel in the on and next states long enough to read them.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int REG_AW = 6;
  localparam int REG_DW = 32;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_RSP,
    PH_SEND,
    PH_FIN
  } mv_phase_e;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_INTR  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_PORT  = 6'h08;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_REM   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_CNT0  = 6'h20;
  localparam logic [REG_AW-1:0] OFS_BASE0 = 6'h24;
  localparam logic [REG_AW-1:0] OFS_CNT1  = 6'h30;
  localparam logic [REG_AW-1:0] OFS_BASE1 = 6'h34;

  localparam int CB_STALL_IE = 0;
  localparam int CB_NFB_IE   = 1;
  localparam int CB_ERR_IE   = 3;
  localparam int CB_EN       = 4;
  localparam logic [4:0] CTRL_MASK = 5'b11011;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  ch_state_e         state,
  input  logic [1:0]        slot_vld,
  input  logic [CNT_W-1:0]  remain,
  input  logic              set_stall,
  input  logic              set_nfb,
  input  logic              set_err,
  input  logic              commit_acc,
  output logic              en_eff,
  output logic              commit_req,
  output logic              commit_slot,
  output logic [ADDR_W-1:0] slot_base [2],
  output logic [CNT_W-1:0]  slot_cnt [2],
  output logic [PORT_W-1:0] per_port,
  output logic              err_flag,
  output logic              irq
);
  logic [4:0] ctrl_q;
  logic       stall_q, nfb_q;
  logic       wr_ctrl, wr_intr, wr_port, rd_ctrl;
  logic [1:0] wr_cnt, wr_base;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_intr = reg_wr && (reg_addr == OFS_INTR);
  assign wr_port = reg_wr && (reg_addr == OFS_PORT);
  assign rd_ctrl = reg_rd && (reg_addr == OFS_CTRL);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam logic [REG_AW-1:0] CNT_OFS  = (s == 0) ? OFS_CNT0 : OFS_CNT1;
    localparam logic [REG_AW-1:0] BASE_OFS = (s == 0) ? OFS_BASE0 : OFS_BASE1;
    assign wr_cnt[s]  = reg_wr && (reg_addr == CNT_OFS) && !slot_vld[s];
    assign wr_base[s] = reg_wr && (reg_addr == BASE_OFS) && !slot_vld[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_cnt[s]  <= '0;
        slot_base[s] <= '0;
      end else begin
        if (wr_cnt[s])  slot_cnt[s]  <= reg_wdata[CNT_W-1:0];
        if (wr_base[s]) slot_base[s] <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      en_eff      <= 1'b0;
      per_port    <= '0;
      stall_q     <= 1'b0;
      nfb_q       <= 1'b0;
      err_flag    <= 1'b0;
      commit_req  <= 1'b0;
      commit_slot <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[4:0] & CTRL_MASK;
      if (rd_ctrl) en_eff <= wr_ctrl ? reg_wdata[CB_EN] : ctrl_q[CB_EN];
      if (wr_port) per_port <= reg_wdata[PORT_W-1:0];

      if (set_stall)       stall_q <= 1'b1;
      else if (commit_acc) stall_q <= 1'b0;
      if (set_nfb)         nfb_q <= 1'b1;
      else if (commit_acc) nfb_q <= 1'b0;
      if (set_err)                   err_flag <= 1'b1;
      else if (wr_intr && reg_wdata[3]) err_flag <= 1'b0;

      commit_req  <= |wr_base;
      commit_slot <= wr_base[1];
    end
  end

  assign irq = (stall_q && ctrl_q[CB_STALL_IE]) ||
               (nfb_q && ctrl_q[CB_NFB_IE]) ||
               (err_flag && ctrl_q[CB_ERR_IE]);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = REG_DW'(ctrl_q);
      OFS_INTR:  reg_rdata = REG_DW'({err_flag, 1'b0, nfb_q, stall_q});
      OFS_PORT:  reg_rdata = REG_DW'(per_port);
      OFS_STAT:  reg_rdata = REG_DW'({state, 4'b0000});
      OFS_REM:   reg_rdata = REG_DW'(remain);
      OFS_CNT0:  reg_rdata = REG_DW'(slot_cnt[0]);
      OFS_BASE0: reg_rdata = REG_DW'(slot_base[0]);
      OFS_CNT1:  reg_rdata = REG_DW'(slot_cnt[1]);
      OFS_BASE1: reg_rdata = REG_DW'(slot_base[1]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_eff,
  input  logic      commit_req,
  input  logic      commit_slot,
  input  logic      done,
  output ch_state_e state,
  output logic [1:0] slot_vld,
  output logic      load,
  output logic      load_slot,
  output logic      set_stall,
  output logic      set_nfb,
  output logic      commit_acc
);
  logic       active_q, act_q;
  logic       active_n, act_n, oth;
  logic [1:0] vld_c, vld_n;

  always_comb begin
    if (!active_q) state = CH_IDLE;
    else begin
      unique case (slot_vld)
        2'b00:   state = CH_STALL;
        2'b11:   state = CH_NEXT;
        default: state = CH_ON;
      endcase
    end
  end

  always_comb begin
    oth        = ~act_q;
    commit_acc = commit_req && active_q && en_eff && !slot_vld[commit_slot];
    vld_c      = slot_vld;
    if (commit_acc) vld_c[commit_slot] = 1'b1;
    vld_n      = vld_c;
    act_n      = act_q;
    load       = 1'b0;
    load_slot  = act_q;
    set_stall  = 1'b0;
    set_nfb    = 1'b0;
    if (done) begin
      vld_n[act_q] = 1'b0;
      if (vld_c[oth]) begin
        load      = 1'b1;
        load_slot = oth;
        act_n     = oth;
        set_nfb   = 1'b1;
      end else begin
        set_stall = 1'b1;
      end
    end else if (commit_acc && (slot_vld == 2'b00)) begin
      load      = 1'b1;
      load_slot = commit_slot;
      act_n     = commit_slot;
    end
    if (!active_q)                            active_n = en_eff;
    else if (!en_eff && (slot_vld == 2'b00))  active_n = 1'b0;
    else                                      active_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      act_q    <= 1'b0;
      slot_vld <= 2'b00;
    end else begin
      active_q <= active_n;
      act_q    <= act_n;
      slot_vld <= vld_n;
    end
  end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [CNT_W-1:0]  ld_cnt,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              per_valid,
  input  logic              per_ready,
  output logic [DATA_W-1:0] per_data,
  output logic              done,
  output logic              set_err,
  output logic [CNT_W-1:0]  remain
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(BYTES);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(BYTES);

  mv_phase_e         phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign mem_req_valid = (phase == PH_REQ);
  assign mem_req_addr  = addr_q;
  assign per_valid     = (phase == PH_SEND);
  assign per_data      = data_q;
  assign done          = (phase == PH_FIN);
  assign set_err       = (phase == PH_RSP) && mem_rsp_valid && mem_rsp_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      addr_q <= '0;
      data_q <= '0;
      remain <= '0;
    end else if (load) begin
      addr_q <= ld_base;
      remain <= ld_cnt;
      phase  <= (ld_cnt == '0) ? PH_FIN : PH_REQ;
    end else begin
      unique case (phase)
        PH_REQ: if (mem_req_ready) phase <= PH_RSP;
        PH_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              remain <= '0;
              phase  <= PH_FIN;
            end else begin
              data_q <= mem_rsp_data;
              phase  <= PH_SEND;
            end
          end
        end
        PH_SEND: begin
          if (per_ready) begin
            addr_q <= addr_q + ASTEP;
            if (remain <= CSTEP) begin
              remain <= '0;
              phase  <= PH_FIN;
            end else begin
              remain <= remain - CSTEP;
              phase  <= PH_REQ;
            end
          end
        end
        PH_FIN:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              per_valid,
  input  logic              per_ready,
  output logic [DATA_W-1:0] per_data,
  output logic [PORT_W-1:0] per_port,
  output logic              irq
);
  ch_state_e         ch_state;
  logic [1:0]        slot_vld;
  logic [CNT_W-1:0]  cur_remain;
  logic              en_eff, commit_req, commit_slot, commit_acc;
  logic              load, load_slot, done;
  logic              set_stall, set_nfb, set_err, err_flag;
  logic [ADDR_W-1:0] slot_base [2];
  logic [CNT_W-1:0]  slot_cnt [2];

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .state(ch_state), .slot_vld(slot_vld), .remain(cur_remain),
    .set_stall(set_stall), .set_nfb(set_nfb), .set_err(set_err),
    .commit_acc(commit_acc), .en_eff(en_eff),
    .commit_req(commit_req), .commit_slot(commit_slot),
    .slot_base(slot_base), .slot_cnt(slot_cnt),
    .per_port(per_port), .err_flag(err_flag), .irq(irq)
  );

  pdma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en_eff(en_eff),
    .commit_req(commit_req), .commit_slot(commit_slot), .done(done),
    .state(ch_state), .slot_vld(slot_vld), .load(load), .load_slot(load_slot),
    .set_stall(set_stall), .set_nfb(set_nfb), .commit_acc(commit_acc)
  );

  pdma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_base(slot_base[load_slot]), .ld_cnt(slot_cnt[load_slot]),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .per_valid(per_valid), .per_ready(per_ready), .per_data(per_data),
    .done(done), .set_err(set_err), .remain(cur_remain)
  );
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              per_valid,
  input logic              per_ready,
  input logic [DATA_W-1:0] per_data,
  input logic [1:0]        ch_state,
  input logic [CNT_W-1:0]  cur_remain,
  input logic              err_flag
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r13_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && !per_ready |=> per_valid && $stable(per_data));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ch_state == 2'd0 |-> !mem_req_valid && !per_valid);

  a_r6_remain_step: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && per_ready |=>
      cur_remain == (($past(cur_remain) > STEP) ? $past(cur_remain) - STEP : '0));

  a_r7_next_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ch_state == 2'd3 |=> ch_state == 2'd3 || ch_state == 2'd2);

  a_r12_on_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ch_state == 2'd2 |=> ch_state != 2'd0);

  a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ch_state == 2'd0 |=> ch_state == 2'd0 || ch_state == 2'd1);

  a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_err |=> err_flag);
endmodule

bind pdma_chan pdma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_err(mem_rsp_err), .per_valid(per_valid), .per_ready(per_ready),
  .per_data(per_data), .ch_state(ch_state), .cur_remain(cur_remain),
  .err_flag(err_flag)
);

// File: tb/pdma_chan_bench.sv
module pdma_chan_bench;
  localparam int AW = 24, CW = 12, DW = 16, PW = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          per_valid, per_ready = 1'b0;
  logic [DW-1:0] per_data;
  logic [PW-1:0] per_port;
  logic          irq;

  int tests = 0, fails = 0;
  int sink_allow = 0, beats = 0, cyc = 0;
  logic [DW-1:0] got [64];
  logic [AW-1:0] err_addr = '1;
  logic [AW-1:0] pend_addr = '0;
  logic          rsp_due = 1'b0;

  // base[35:12], byte count[11:0]
  localparam logic [35:0] VEC [6] = '{
    {24'h001000, 12'd8}, {24'h0020F0, 12'd6}, {24'h003002, 12'd1},
    {24'h004000, 12'd0}, {24'h7FFFF0, 12'd12}, {24'h00B010, 12'd14}
  };

  pdma_chan #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .PORT_W(PW)) u_pdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .per_valid(per_valid), .per_ready(per_ready), .per_data(per_data),
    .per_port(per_port), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // memory model: ready drops every third cycle, one-cycle response
  initial forever begin
    @(negedge clk);
    cyc++;
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    mem_req_ready = (cyc % 3) != 1;
    if (rsp_due) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mdat(pend_addr);
      mem_rsp_err   = (pend_addr == err_addr);
      rsp_due       = 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      pend_addr = mem_req_addr;
      rsp_due   = 1'b1;
    end
  end

  // peripheral model: accepts words from a budget
  initial forever begin
    @(negedge clk);
    per_ready = (sink_allow > 0);
    if (per_valid && per_ready) begin
      if (beats < 64) got[beats] = per_data;
      beats++;
      sink_allow--;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic st(output logic [31:0] s);
    logic [31:0] v;
    rd(6'h0C, v);
    s = (v >> 4) & 32'h3;
  endtask

  task automatic wait_state(input logic [31:0] exp);
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      st(s);
      if (s == exp) break;
    end
  endtask

  task automatic commit(input bit slot, input logic [AW-1:0] b, input logic [CW-1:0] n);
    wr(slot ? 6'h30 : 6'h20, 32'(n));
    wr(slot ? 6'h34 : 6'h24, 32'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, s;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    st(s);            check("R1 status", s, 0);
    rd(6'h04, v);     check("R1 intr", v, 0);
    rd(6'h14, v);     check("R1 remain", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 req/out idle", 32'({mem_req_valid, per_valid}), 0);

    // R2 port select
    wr(6'h08, 32'h5);
    rd(6'h08, v);     check("R2 port readback", v, 5);
    check("R2 per_port", 32'(per_port), 5);

    // R3 enable deferred until control read
    wr(6'h00, 32'h10);
    settle(4);
    st(s);            check("R3 idle before read", s, 0);
    rd(6'h00, v);     check("R2 ctrl readback", v, 32'h10);
    settle(2);
    st(s);            check("R3 stall after read", s, 1);

    // table of single buffers
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] b;
      logic [CW-1:0] n;
      int exp_beats;
      b = VEC[i][35:12];
      n = VEC[i][11:0];
      exp_beats = (int'(n) + 1) / 2;
      sink_allow = 0;
      beats = 0;
      commit(i[0], b, n);
      settle(3);
      rd(6'h04, v);   check("R9 stall cleared by commit", v & 1, (n == 0) ? 1 : 0);
      st(s);          check("R4 stall->on", s, (n == 0) ? 1 : 2);
      sink_allow = 1000;
      wait_state(1);
      settle(2);
      sink_allow = 0;
      check("R5 word count", beats, exp_beats);
      for (int k = 0; k < exp_beats; k++)
        check("R5/R13 word data", 32'(got[k]), 32'(mdat(b + AW'(2 * k))));
      rd(6'h04, v);   check("R8 stall flag", v & 1, 1);
      rd(6'h14, v);   check("R6 remain at end", v, 0);
    end

    // R4/R7 ping-pong with two slots
    sink_allow = 0;
    beats = 0;
    commit(1'b0, 24'h010000, 12'd4);
    commit(1'b1, 24'h020000, 12'd4);
    settle(3);
    st(s);            check("R4 on->next", s, 3);
    wr(6'h24, 32'h0FFFFF);
    settle(2);
    rd(6'h24, v);     check("R4 loaded slot write ignored", v, 32'h010000);
    st(s);            check("R4 ignored commit keeps next", s, 3);
    sink_allow = 2;
    settle(20);
    st(s);            check("R7 next->on", s, 2);
    rd(6'h04, v);     check("R7 nfb flag", v & 2, 2);
    sink_allow = 2;
    settle(20);
    st(s);            check("R8 on->stall", s, 1);
    check("R7 words", beats, 4);
    check("R7 w0", 32'(got[0]), 32'(mdat(24'h010000)));
    check("R7 w1", 32'(got[1]), 32'(mdat(24'h010002)));
    check("R7 w2", 32'(got[2]), 32'(mdat(24'h020000)));
    check("R7 w3", 32'(got[3]), 32'(mdat(24'h020002)));
    wr(6'h04, 32'h3);
    rd(6'h04, v);     check("R9 write does not clear", v & 3, 3);

    // R11 irq masking
    settle(1);        check("R11 masked", 32'(irq), 0);
    wr(6'h00, 32'h12); settle(1); check("R11 nfb enable", 32'(irq), 1);
    wr(6'h00, 32'h11); settle(1); check("R11 stall enable", 32'(irq), 1);
    wr(6'h00, 32'h18); settle(1); check("R11 err enable only", 32'(irq), 0);
    wr(6'h00, 32'h10);

    // R6 remaining count mid-buffer
    sink_allow = 2;
    beats = 0;
    commit(1'b0, 24'h030000, 12'd10);
    settle(30);
    rd(6'h14, v);     check("R6 remain after two words", v, 6);
    sink_allow = 100;
    wait_state(1);

    // R10 memory error
    sink_allow = 100;
    beats = 0;
    err_addr = 24'h040002;
    commit(1'b1, 24'h040000, 12'd8);
    settle(40);
    err_addr = '1;
    check("R10 words before error", beats, 1);
    rd(6'h04, v);     check("R10 error flag", v & 8, 8);
    check("R10 advance sets stall", v & 1, 1);
    st(s);            check("R10 state stall", s, 1);
    wr(6'h00, 32'h18); settle(1); check("R11 err irq", 32'(irq), 1);
    wr(6'h04, 32'h8);
    rd(6'h04, v);     check("R10 w1c", v & 8, 0);
    check("R11 irq after clear", 32'(irq), 0);
    wr(6'h00, 32'h10);

    // R12 disable drains then idles
    sink_allow = 0;
    beats = 0;
    commit(1'b0, 24'h050000, 12'd4);
    settle(3);
    wr(6'h00, 32'h00);
    rd(6'h00, v);
    settle(5);
    st(s);            check("R12 still on after disable", s, 2);
    sink_allow = 10;
    wait_state(0);
    check("R12 buffer finished", beats, 2);
    st(s);            check("R12 idle", s, 0);

    // R4 commit while idle ignored
    beats = 0;
    commit(1'b1, 24'h060000, 12'd4);
    settle(5);
    st(s);            check("R4 idle commit ignored", s, 0);
    check("R4 no request while idle", 32'(mem_req_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule